// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device virtual address into a physical address. It walks a two-level translation table held in ordinary memory. A client presents the virtual address together with the base of the first-level table. The walker then fetches one 32-bit descriptor per level through a single-word read port. A section descriptor ends the walk after one fetch. A table pointer leads to a second fetch from a 1 KB-aligned second-level table.

The walker returns one of three things: the translated address and the size of the mapping that produced it, or a fault that reports the offending virtual address and the level at which the walk stopped. There is no caching. Every request costs one or two memory reads. The memory may take any number of cycles to answer, and the walker simply waits for read-data-valid.

Top module: `xlat_walker`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0. A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until the response has been given, and requests presented while it is low have no effect.
- R2: The first fetch reads address `req_table_base + 4 * vaddr[31:20]`, computed with a full adder, so the base need not be aligned.
- R3: A first-level descriptor whose bits 1:0 are `10` is a 1 MB section. The response gives `rsp_paddr = {desc[31:20], vaddr[19:0]}` and `rsp_size = 2`, after exactly one read.
- R4: A first-level descriptor whose bits 1:0 are `01` causes a second fetch from `{desc[31:10], 10'b0} + 4 * vaddr[19:12]`.
- R5: A first-level descriptor whose bits 1:0 are `00` or `11` ends the walk with `rsp_fault = 1` and `rsp_fault_lvl2 = 0`. No second read is issued.
- R6: A second-level descriptor whose bits 1:0 are `00` gives `rsp_fault = 1` and `rsp_fault_lvl2 = 1`.
- R7: A second-level descriptor whose bits 1:0 are `01` is a 64 KB page. The response gives `rsp_paddr = {desc[31:16], vaddr[15:0]}` and `rsp_size = 1`. Because such a page is stored as 16 identical descriptors, any vaddr[15:12] within it gives the same page base.
- R8: A second-level descriptor with bit 1 set (`10` or `11`) is a 4 KB page. The response gives `rsp_paddr = {desc[31:12], vaddr[11:0]}` and `rsp_size = 0`.
- R9: Each fetch raises `mem_rd_en` for exactly one cycle. The walker keeps at most one read outstanding and waits an arbitrary number of cycles for `mem_rd_valid`.
- R10: `rsp_valid` is a one-cycle pulse. `rsp_vaddr` carries the request's virtual address with every response, `rsp_paddr` and `rsp_size` read 0 on a fault, and `req_ready` is 1 in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 32 | Virtual address to translate |
| req_table_base | input | 32 | Byte address of the first-level table |
| mem_rd_en | output | 1 | One-cycle descriptor read strobe |
| mem_rd_addr | output | 32 | Descriptor byte address |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Translation fault |
| rsp_fault_lvl2 | output | 1 | Fault found at second level (0 = first level) |
| rsp_size | output | 2 | Mapping size: 0 = 4 KB, 1 = 64 KB, 2 = 1 MB |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_vaddr | output | 32 | Virtual address of the request answered |

## Verification
The in-RTL properties watch the handshake shape on every cycle: read strobes last one cycle, response pulses last one cycle and are followed by readiness, and a successful response keeps the page-offset bits of the virtual address that match its reported size. They also check that faults report a zero physical address. The descriptor decoding can only be shown by the bench's scenarios. This covers which fetch addresses are formed, which bit patterns fault at which level, the number of reads per walk, the equivalence of all sixteen copies of a large page, tolerance of long read latencies, and the ignoring of requests made while busy.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_L1_RD,
      ST_L1_WAIT,
      ST_L2_RD,
      ST_L2_WAIT,
      ST_RESP
   } walk_st_t;

   typedef enum logic [1:0] {
      SZ_SMALL = 2'd0,
      SZ_LARGE = 2'd1,
      SZ_SECT  = 2'd2
   } map_sz_t;

   typedef enum logic [1:0] {
      K1_FAULT,
      K1_TABLE,
      K1_SECTION
   } l1_kind_t;

   typedef enum logic [1:0] {
      K2_FAULT,
      K2_LARGE,
      K2_SMALL
   } l2_kind_t;

endpackage

// File: rtl/xlat_l1_addr.sv
module xlat_l1_addr #(
   parameter int AW      = 32,
   parameter int IDX_W   = 12,
   parameter bit ALIGNED = 1'b0
) (
   input  logic [AW-1:0]    base,
   input  logic [IDX_W-1:0] idx,
   output logic [AW-1:0]    addr
);
   localparam int PAD_W = AW - IDX_W - 2;

   if (PAD_W < 0) begin : g_bad_width
      $error("xlat_l1_addr: index does not fit the address width");
   end

   if (ALIGNED) begin : g_concat
      // base assumed aligned to the table size: no carry chain
      assign addr = {base[AW-1:IDX_W+2], idx, 2'b00};
   end else begin : g_adder
      assign addr = base + {{PAD_W{1'b0}}, idx, 2'b00};
   end
endmodule

// File: rtl/xlat_l1_decode.sv
module xlat_l1_decode
   import xlat_pkg::*;
#(
   parameter int AW       = 32,
   parameter int SECT_SH  = 20,
   parameter int SPAGE_SH = 12,
   parameter int L2_AL_SH = 10
) (
   input  logic [AW-1:0] desc,
   input  logic [AW-1:0] va,
   output l1_kind_t      kind,
   output logic [AW-1:0] sect_pa,
   output logic [AW-1:0] l2_addr
);
   localparam int L2_IDX_W = SECT_SH - SPAGE_SH;

   if (L2_IDX_W + 2 != L2_AL_SH) begin : g_bad_align
      $error("xlat_l1_decode: second-level table size must equal its alignment");
   end

   always_comb begin
      unique case (desc[1:0])
         2'b01:   kind = K1_TABLE;
         2'b10:   kind = K1_SECTION;
         default: kind = K1_FAULT;
      endcase
   end

   assign sect_pa = {desc[AW-1:SECT_SH], va[SECT_SH-1:0]};
   // alignment equals table size, so the index concatenates below the base
   assign l2_addr = {desc[AW-1:L2_AL_SH], va[SECT_SH-1:SPAGE_SH], 2'b00};
endmodule

// File: rtl/xlat_l2_decode.sv
module xlat_l2_decode
   import xlat_pkg::*;
#(
   parameter int AW       = 32,
   parameter int LPAGE_SH = 16,
   parameter int SPAGE_SH = 12
) (
   input  logic [AW-1:0] desc,
   input  logic [AW-1:0] va,
   output l2_kind_t      kind,
   output logic [AW-1:0] pa
);
   if (LPAGE_SH <= SPAGE_SH) begin : g_bad_sizes
      $error("xlat_l2_decode: large page must exceed small page");
   end

   always_comb begin
      if (desc[1]) begin
         kind = K2_SMALL;
         pa   = {desc[AW-1:SPAGE_SH], va[SPAGE_SH-1:0]};
      end else if (desc[0]) begin
         kind = K2_LARGE;
         pa   = {desc[AW-1:LPAGE_SH], va[LPAGE_SH-1:0]};
      end else begin
         kind = K2_FAULT;
         pa   = '0;
      end
   end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
   import xlat_pkg::*;
#(
   parameter int AW          = 32,
   parameter int SECT_SH     = 20,
   parameter int LPAGE_SH    = 16,
   parameter int SPAGE_SH    = 12,
   parameter int L2_AL_SH    = 10,
   parameter bit BASE_ALIGNED = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_vaddr,
   input  logic [AW-1:0] req_table_base,
   output logic          mem_rd_en,
   output logic [AW-1:0] mem_rd_addr,
   input  logic          mem_rd_valid,
   input  logic [AW-1:0] mem_rd_data,
   output logic          rsp_valid,
   output logic          rsp_fault,
   output logic          rsp_fault_lvl2,
   output logic [1:0]    rsp_size,
   output logic [AW-1:0] rsp_paddr,
   output logic [AW-1:0] rsp_vaddr
);
   localparam int L1_IDX_W = AW - SECT_SH;

   if (AW != 32) begin : g_bad_aw
      $error("xlat_walker: descriptors are one 32-bit word");
   end
   if (!(SECT_SH > LPAGE_SH && LPAGE_SH > SPAGE_SH && SPAGE_SH > L2_AL_SH)) begin : g_bad_order
      $error("xlat_walker: granule shifts out of order");
   end

   walk_st_t      st_q;
   logic [AW-1:0] va_q, base_q, l2_addr_q;
   logic          fault_q, lvl2_q;
   logic [1:0]    size_q;
   logic [AW-1:0] pa_q;

   logic [AW-1:0] l1_addr;
   l1_kind_t      k1;
   logic [AW-1:0] sect_pa, l2_addr;
   l2_kind_t      k2;
   logic [AW-1:0] page_pa;

   xlat_l1_addr #(.AW(AW), .IDX_W(L1_IDX_W), .ALIGNED(BASE_ALIGNED)) u_l1_addr (
      .base (base_q),
      .idx  (va_q[AW-1:SECT_SH]),
      .addr (l1_addr)
   );

   xlat_l1_decode #(.AW(AW), .SECT_SH(SECT_SH), .SPAGE_SH(SPAGE_SH), .L2_AL_SH(L2_AL_SH)) u_l1_dec (
      .desc    (mem_rd_data),
      .va      (va_q),
      .kind    (k1),
      .sect_pa (sect_pa),
      .l2_addr (l2_addr)
   );

   xlat_l2_decode #(.AW(AW), .LPAGE_SH(LPAGE_SH), .SPAGE_SH(SPAGE_SH)) u_l2_dec (
      .desc (mem_rd_data),
      .va   (va_q),
      .kind (k2),
      .pa   (page_pa)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         va_q      <= '0;
         base_q    <= '0;
         l2_addr_q <= '0;
         fault_q   <= 1'b0;
         lvl2_q    <= 1'b0;
         size_q    <= 2'd0;
         pa_q      <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q   <= req_vaddr;
                  base_q <= req_table_base;
                  st_q   <= ST_L1_RD;
               end
            end
            ST_L1_RD: st_q <= ST_L1_WAIT;
            ST_L1_WAIT: begin
               if (mem_rd_valid) begin
                  unique case (k1)
                     K1_SECTION: begin
                        fault_q <= 1'b0;
                        lvl2_q  <= 1'b0;
                        size_q  <= SZ_SECT;
                        pa_q    <= sect_pa;
                        st_q    <= ST_RESP;
                     end
                     K1_TABLE: begin
                        l2_addr_q <= l2_addr;
                        st_q      <= ST_L2_RD;
                     end
                     default: begin
                        fault_q <= 1'b1;
                        lvl2_q  <= 1'b0;
                        size_q  <= SZ_SMALL;
                        pa_q    <= '0;
                        st_q    <= ST_RESP;
                     end
                  endcase
               end
            end
            ST_L2_RD: st_q <= ST_L2_WAIT;
            ST_L2_WAIT: begin
               if (mem_rd_valid) begin
                  fault_q <= (k2 == K2_FAULT);
                  lvl2_q  <= (k2 == K2_FAULT);
                  size_q  <= (k2 == K2_LARGE) ? SZ_LARGE : SZ_SMALL;
                  pa_q    <= page_pa;
                  st_q    <= ST_RESP;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready      = (st_q == ST_IDLE);
   assign mem_rd_en      = (st_q == ST_L1_RD) || (st_q == ST_L2_RD);
   assign mem_rd_addr    = (st_q == ST_L2_RD) ? l2_addr_q : l1_addr;
   assign rsp_valid      = (st_q == ST_RESP);
   assign rsp_fault      = rsp_valid & fault_q;
   assign rsp_fault_lvl2 = rsp_valid & lvl2_q;
   assign rsp_size       = rsp_valid ? size_q : 2'd0;
   assign rsp_paddr      = rsp_valid ? pa_q : '0;
   assign rsp_vaddr      = va_q;

   // R9: every descriptor read strobe lasts a single cycle
   p_rd_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   // R10: response is a pulse and the walker is ready right after it
   p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> (!rsp_valid && req_ready));

   // R1: no readiness while a read or response is in flight
   p_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en || rsp_valid) |-> !req_ready);

   // R3: sections keep the low 20 virtual bits
   p_sect_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault && rsp_size == SZ_SECT) |->
         rsp_paddr[SECT_SH-1:0] == rsp_vaddr[SECT_SH-1:0]);

   // R7: large pages keep the low 16 virtual bits
   p_large_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault && rsp_size == SZ_LARGE) |->
         rsp_paddr[LPAGE_SH-1:0] == rsp_vaddr[LPAGE_SH-1:0]);

   // R8: small pages keep the low 12 virtual bits
   p_small_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_fault && rsp_size == SZ_SMALL) |->
         rsp_paddr[SPAGE_SH-1:0] == rsp_vaddr[SPAGE_SH-1:0]);

   // R10: faults carry no physical address
   p_fault_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_size == 2'd0));
endmodule

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [31:0] req_table_base = '0;
   logic        mem_rd_en;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        rsp_valid, rsp_fault, rsp_fault_lvl2;
   logic [1:0]  rsp_size;
   logic [31:0] rsp_paddr, rsp_vaddr;

   int errors = 0;
   int checks = 0;
   int mem_lat = 1;
   int rd_count = 0;
   logic [31:0] rd_log [0:3];
   bit done = 0;

   logic [31:0] mem [logic [31:0]];

   always #2 clk = ~clk;

   xlat_walker u_xlat_walker (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_table_base(req_table_base),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_fault_lvl2(rsp_fault_lvl2),
      .rsp_size(rsp_size), .rsp_paddr(rsp_paddr), .rsp_vaddr(rsp_vaddr)
   );

   // memory model: answers each strobe after mem_lat cycles
   initial begin
      int cnt;
      logic busy;
      logic [31:0] a;
      cnt = 0; busy = 0; a = '0;
      forever begin
         @(negedge clk);
         mem_rd_valid = 1'b0;
         if (busy) begin
            if (cnt <= 1) begin
               mem_rd_valid = 1'b1;
               mem_rd_data  = mem.exists(a) ? mem[a] : 32'h0;
               busy = 0;
            end else cnt--;
         end
         if (mem_rd_en) begin
            a = mem_rd_addr;
            if (rd_count < 4) rd_log[rd_count] = a;
            rd_count++;
            busy = 1;
            cnt = mem_lat;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic walk(input logic [31:0] va, input logic [31:0] base, input int lat);
      int t;
      mem_lat = lat;
      rd_count = 0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_vaddr = va;
      req_table_base = base;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      t = 0;
      while (!rsp_valid && t < 500) begin
         @(negedge clk);
         t++;
      end
      check("R9 response arrives", {31'd0, rsp_valid}, 32'd1);
   endtask

   task automatic expect_ok(input string req, input logic [31:0] va, input logic [31:0] pa,
                            input logic [1:0] sz, input int nrd);
      check({req, " fault"}, {31'd0, rsp_fault}, 32'd0);
      check({req, " paddr"}, rsp_paddr, pa);
      check({req, " size"}, {30'd0, rsp_size}, {30'd0, sz});
      check({req, " vaddr echo R10"}, rsp_vaddr, va);
      check({req, " read count"}, rd_count, nrd);
   endtask

   task automatic t_reset_r1;
      check("R1 ready at reset", {31'd0, req_ready}, 32'd1);
      check("R1 no rsp at reset", {31'd0, rsp_valid}, 32'd0);
      check("R1 no read at reset", {31'd0, mem_rd_en}, 32'd0);
   endtask

   task automatic t_section_r3;
      walk(32'h1234_5678, 32'h0001_0000, 1);
      check("R2 l1 address", rd_log[0], 32'h0001_048C);
      expect_ok("R3 section", 32'h1234_5678, 32'hABC4_5678, 2'd2, 1);
      @(negedge clk);
      check("R10 pulse ends", {31'd0, rsp_valid}, 32'd0);
      check("R10 ready after", {31'd0, req_ready}, 32'd1);
   endtask

   task automatic t_unaligned_r2;
      walk(32'h0010_0010, 32'h0003_0008, 2);
      check("R2 unaligned base address", rd_log[0], 32'h0003_000C);
      expect_ok("R2 section via unaligned base", 32'h0010_0010, 32'h0F00_0010, 2'd2, 1);
   endtask

   task automatic t_small_r8;
      walk(32'h2003_5ABC, 32'h0001_0000, 1);
      check("R4 l2 address", rd_log[1], 32'h0002_04D4);
      expect_ok("R8 small 10", 32'h2003_5ABC, 32'h8765_4ABC, 2'd0, 2);
      walk(32'h2003_6123, 32'h0001_0000, 3);
      check("R4 l2 address b", rd_log[1], 32'h0002_04D8);
      expect_ok("R8 small 11", 32'h2003_6123, 32'h1111_2123, 2'd0, 2);
   endtask

   task automatic t_large_r7;
      walk(32'h2004_A321, 32'h0001_0000, 1);
      check("R4 l2 address large", rd_log[1], 32'h0002_0528);
      expect_ok("R7 large copy 10", 32'h2004_A321, 32'h5555_A321, 2'd1, 2);
      walk(32'h2004_0007, 32'h0001_0000, 2);
      expect_ok("R7 large copy 0", 32'h2004_0007, 32'h5555_0007, 2'd1, 2);
      walk(32'h2004_FFFF, 32'h0001_0000, 1);
      expect_ok("R7 large copy 15", 32'h2004_FFFF, 32'h5555_FFFF, 2'd1, 2);
   endtask

   task automatic t_l1_fault_r5;
      walk(32'h7FF0_0000, 32'h0001_0000, 1);
      check("R5 fault 00", {31'd0, rsp_fault}, 32'd1);
      check("R5 level 1", {31'd0, rsp_fault_lvl2}, 32'd0);
      check("R5 fault addr", rsp_vaddr, 32'h7FF0_0000);
      check("R5 one read", rd_count, 32'd1);
      check("R10 fault paddr zero", rsp_paddr, 32'h0);
      walk(32'h3000_1234, 32'h0001_0000, 2);
      check("R5 fault 11", {31'd0, rsp_fault}, 32'd1);
      check("R5 level 1 b", {31'd0, rsp_fault_lvl2}, 32'd0);
      check("R5 one read b", rd_count, 32'd1);
   endtask

   task automatic t_l2_fault_r6;
      walk(32'h2009_0ABC, 32'h0001_0000, 1);
      check("R6 fault", {31'd0, rsp_fault}, 32'd1);
      check("R6 level 2", {31'd0, rsp_fault_lvl2}, 32'd1);
      check("R6 fault addr", rsp_vaddr, 32'h2009_0ABC);
      check("R6 two reads", rd_count, 32'd2);
   endtask

   task automatic t_latency_r9;
      walk(32'h2003_5ABC, 32'h0001_0000, 9);
      expect_ok("R9 long latency", 32'h2003_5ABC, 32'h8765_4ABC, 2'd0, 2);
   endtask

   task automatic t_busy_r1;
      int t;
      mem_lat = 4;
      rd_count = 0;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_vaddr = 32'h1234_5678; req_table_base = 32'h0001_0000; req_valid = 1'b1;
      @(negedge clk);
      check("R1 busy after accept", {31'd0, req_ready}, 32'd0);
      req_vaddr = 32'h7FF0_0000;
      @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      t = 0;
      while (!rsp_valid && t < 500) begin @(negedge clk); t++; end
      expect_ok("R1 busy request ignored", 32'h1234_5678, 32'hABC4_5678, 2'd2, 1);
   endtask

   initial begin
      mem[32'h0001_048C] = 32'hABC0_0002;
      mem[32'h0003_000C] = 32'h0F00_0002;
      mem[32'h0001_0800] = 32'h0002_0401;
      mem[32'h0001_0C00] = 32'h1234_5003;
      mem[32'h0002_04D4] = 32'h8765_4002;
      mem[32'h0002_04D8] = 32'h1111_2003;
      for (int i = 0; i < 16; i++) mem[32'h0002_0500 + 4 * i] = 32'h5555_0001;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_r1();
      t_section_r3();
      t_unaligned_r2();
      t_small_r8();
      t_large_r7();
      t_l1_fault_r5();
      t_l2_fault_r6();
      t_latency_r9();
      t_busy_r1();
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule